// File: doc/BRIEF.md
# Synchronous Exception Priority Selector

This block resolves the synchronous exceptions that a single instruction may raise on a processor that supports a hypervisor. Each cycle it gathers condition flags from several sources. The fetch unit supplies an instruction breakpoint. The instruction translator reports the first fault it found. The decoder supplies illegal instruction, virtual instruction, environment call and environment break. The memory stage supplies a data breakpoint, a misaligned access and the first fault found by the data translator. Two checks after translation supply access faults. The block reports one winner as a valid bit and a 5-bit cause code.

A translator gives its result as a valid bit plus the cause code of the first fault it met. The selector passes that code through unchanged, so ranking within a translation phase follows arrival order, not fault type. The environment call code comes from the current privilege level and the virtualization bit. A load/store select picks between the load and store/AMO variants of the misaligned and access-fault codes. The parameter `MISALIGNED_HIGH` sets the rank of a misaligned data access. The parameter `REGISTERED` adds an output register.

Top module: `sync_exc_sel`

## Requirements
- R1: An instruction address breakpoint outranks every other condition and reports cause 3.
- R2: Below R1, a valid instruction translation fault reports its supplied code (12, 20 or 1) unchanged and outranks every condition listed after it.
- R3: Below R2, an instruction access fault found at the physical address reports cause 1.
- R4: Below R3 the order is fixed: illegal instruction (2), then virtual instruction (22), then instruction misaligned (0), then environment call, then environment break (3), then data address breakpoint (3).
- R5: The environment call cause is 11 when priv[1] is 1; 9 when priv is 2'b01 and virt is 0; 10 when priv is 2'b01 and virt is 1; and 8 when priv is 2'b00, whatever the value of virt.
- R6: With MISALIGNED_HIGH=1, a misaligned data access ranks directly after the data breakpoint, above data translation and data access faults.
- R7: With MISALIGNED_HIGH=0, a misaligned data access ranks below every other condition.
- R8: A valid data translation fault reports its supplied code (13, 15, 21, 23, 5 or 7) unchanged and outranks the data access fault.
- R9: is_store=0 selects codes 4 (misaligned) and 5 (access fault); is_store=1 selects 6 and 7.
- R10: When no condition is asserted, the valid output is 0 and the cause output is 0.
- R11: With REGISTERED=1 the outputs lag the inputs by exactly one clock, and a low rst_n at a clock edge sets valid and cause to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset of the output register |
| fetch_bkpt_i | input | 1 | Instruction address breakpoint |
| itr_flt_vld_i | input | 1 | Instruction translator reported a fault |
| itr_flt_code_i | input | 5 | Cause of the first instruction translation fault |
| ipa_acc_flt_i | input | 1 | Instruction access fault at the physical address |
| illegal_i | input | 1 | Illegal instruction |
| virt_instr_i | input | 1 | Virtual instruction |
| imisalign_i | input | 1 | Instruction address misaligned |
| ecall_i | input | 1 | Environment call |
| priv_i | input | 2 | Current privilege level (00 user, 01 supervisor, 11 machine) |
| virt_i | input | 1 | Virtualization mode active |
| ebreak_i | input | 1 | Environment break |
| mem_bkpt_i | input | 1 | Load/store/AMO address breakpoint |
| dmisalign_i | input | 1 | Load/store/AMO address misaligned |
| is_store_i | input | 1 | Access is a store or AMO (1) or a load (0) |
| dtr_flt_vld_i | input | 1 | Data translator reported a fault |
| dtr_flt_code_i | input | 5 | Cause of the first data translation fault |
| dpa_acc_flt_i | input | 1 | Data access fault at the physical address |
| exc_vld_o | output | 1 | An exception won |
| exc_cause_o | output | 5 | Cause code of the winning exception |

## Verification
The bench builds two copies that share their inputs. One has MISALIGNED_HIGH=1 and REGISTERED=1. The other has MISALIGNED_HIGH=0 and REGISTERED=0. Each vector therefore checks both misaligned rankings against the same data translation and access faults, and compares the registered copy with the combinational copy in the cycle between input change and clock edge, which tests the one-cycle latency. The registered copy also covers the output reset.

// File: rtl/sxp_pkg.sv
package sxp_pkg;
    localparam int CAUSE_W = 5;

    localparam logic [CAUSE_W-1:0] C_IMISALIGN = 5'd0;
    localparam logic [CAUSE_W-1:0] C_IACCESS   = 5'd1;
    localparam logic [CAUSE_W-1:0] C_ILLEGAL   = 5'd2;
    localparam logic [CAUSE_W-1:0] C_BREAK     = 5'd3;
    localparam logic [CAUSE_W-1:0] C_LD_MIS    = 5'd4;
    localparam logic [CAUSE_W-1:0] C_LD_ACC    = 5'd5;
    localparam logic [CAUSE_W-1:0] C_ST_MIS    = 5'd6;
    localparam logic [CAUSE_W-1:0] C_ST_ACC    = 5'd7;
    localparam logic [CAUSE_W-1:0] C_ECALL_U   = 5'd8;
    localparam logic [CAUSE_W-1:0] C_ECALL_HS  = 5'd9;
    localparam logic [CAUSE_W-1:0] C_ECALL_VS  = 5'd10;
    localparam logic [CAUSE_W-1:0] C_ECALL_M   = 5'd11;
    localparam logic [CAUSE_W-1:0] C_VIRT_INST = 5'd22;

    typedef struct packed {
        logic               vld;
        logic [CAUSE_W-1:0] cause;
    } exc_res_t;
endpackage

// File: rtl/ecall_code_gen.sv
module ecall_code_gen
    import sxp_pkg::*;
(
    input  logic [1:0]         priv_i,
    input  logic               virt_i,
    output logic [CAUSE_W-1:0] code_o
);
    always_comb begin
        if (priv_i[1])          code_o = C_ECALL_M;
        else if (priv_i[0])     code_o = virt_i ? C_ECALL_VS : C_ECALL_HS;
        else                    code_o = C_ECALL_U;
    end
endmodule

// File: rtl/prio_chain.sv
module prio_chain
    import sxp_pkg::*;
#(
    parameter bit MISALIGNED_HIGH = 1'b1
) (
    input  logic               fetch_bkpt_i,
    input  logic               itr_flt_vld_i,
    input  logic [CAUSE_W-1:0] itr_flt_code_i,
    input  logic               ipa_acc_flt_i,
    input  logic               illegal_i,
    input  logic               virt_instr_i,
    input  logic               imisalign_i,
    input  logic               ecall_i,
    input  logic [CAUSE_W-1:0] ecall_code_i,
    input  logic               ebreak_i,
    input  logic               mem_bkpt_i,
    input  logic               dmisalign_i,
    input  logic               is_store_i,
    input  logic               dtr_flt_vld_i,
    input  logic [CAUSE_W-1:0] dtr_flt_code_i,
    input  logic               dpa_acc_flt_i,
    output exc_res_t           res_o
);
    localparam int N_SRC    = 12;
    localparam int FIXED_N  = 9;

    logic [N_SRC-1:0]   cand_vld;
    logic [CAUSE_W-1:0] cand_code [N_SRC];

    // Slots 0..8 never move; slot 0 is the strongest.
    assign cand_vld[0] = fetch_bkpt_i;   assign cand_code[0] = C_BREAK;
    assign cand_vld[1] = itr_flt_vld_i;  assign cand_code[1] = itr_flt_code_i;
    assign cand_vld[2] = ipa_acc_flt_i;  assign cand_code[2] = C_IACCESS;
    assign cand_vld[3] = illegal_i;      assign cand_code[3] = C_ILLEGAL;
    assign cand_vld[4] = virt_instr_i;   assign cand_code[4] = C_VIRT_INST;
    assign cand_vld[5] = imisalign_i;    assign cand_code[5] = C_IMISALIGN;
    assign cand_vld[6] = ecall_i;        assign cand_code[6] = ecall_code_i;
    assign cand_vld[7] = ebreak_i;       assign cand_code[7] = C_BREAK;
    assign cand_vld[8] = mem_bkpt_i;     assign cand_code[8] = C_BREAK;

    logic [CAUSE_W-1:0] mis_code, acc_code;
    assign mis_code = is_store_i ? C_ST_MIS : C_LD_MIS;
    assign acc_code = is_store_i ? C_ST_ACC : C_LD_ACC;

    // The misaligned data slot sits either first or last of the data group.
    generate
        if (MISALIGNED_HIGH) begin : g_mis_high
            assign cand_vld[FIXED_N]   = dmisalign_i;   assign cand_code[FIXED_N]   = mis_code;
            assign cand_vld[FIXED_N+1] = dtr_flt_vld_i; assign cand_code[FIXED_N+1] = dtr_flt_code_i;
            assign cand_vld[FIXED_N+2] = dpa_acc_flt_i; assign cand_code[FIXED_N+2] = acc_code;
        end else begin : g_mis_low
            assign cand_vld[FIXED_N]   = dtr_flt_vld_i; assign cand_code[FIXED_N]   = dtr_flt_code_i;
            assign cand_vld[FIXED_N+1] = dpa_acc_flt_i; assign cand_code[FIXED_N+1] = acc_code;
            assign cand_vld[FIXED_N+2] = dmisalign_i;   assign cand_code[FIXED_N+2] = mis_code;
        end
    endgenerate

    // Scan from weakest to strongest so the strongest assignment lands last.
    always_comb begin
        res_o = '0;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (cand_vld[i]) begin
                res_o.vld   = 1'b1;
                res_o.cause = cand_code[i];
            end
        end
    end
endmodule

// File: rtl/sync_exc_sel.sv
module sync_exc_sel
    import sxp_pkg::*;
#(
    parameter bit MISALIGNED_HIGH = 1'b1,
    parameter bit REGISTERED      = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fetch_bkpt_i,
    input  logic               itr_flt_vld_i,
    input  logic [CAUSE_W-1:0] itr_flt_code_i,
    input  logic               ipa_acc_flt_i,
    input  logic               illegal_i,
    input  logic               virt_instr_i,
    input  logic               imisalign_i,
    input  logic               ecall_i,
    input  logic [1:0]         priv_i,
    input  logic               virt_i,
    input  logic               ebreak_i,
    input  logic               mem_bkpt_i,
    input  logic               dmisalign_i,
    input  logic               is_store_i,
    input  logic               dtr_flt_vld_i,
    input  logic [CAUSE_W-1:0] dtr_flt_code_i,
    input  logic               dpa_acc_flt_i,
    output logic               exc_vld_o,
    output logic [CAUSE_W-1:0] exc_cause_o
);
    typedef struct packed {
        exc_res_t out;
    } sel_state_t;

    logic [CAUSE_W-1:0] ecall_code;
    exc_res_t           res;

    ecall_code_gen u_ecall (
        .priv_i (priv_i),
        .virt_i (virt_i),
        .code_o (ecall_code)
    );

    prio_chain #(.MISALIGNED_HIGH(MISALIGNED_HIGH)) u_chain (
        .fetch_bkpt_i   (fetch_bkpt_i),
        .itr_flt_vld_i  (itr_flt_vld_i),
        .itr_flt_code_i (itr_flt_code_i),
        .ipa_acc_flt_i  (ipa_acc_flt_i),
        .illegal_i      (illegal_i),
        .virt_instr_i   (virt_instr_i),
        .imisalign_i    (imisalign_i),
        .ecall_i        (ecall_i),
        .ecall_code_i   (ecall_code),
        .ebreak_i       (ebreak_i),
        .mem_bkpt_i     (mem_bkpt_i),
        .dmisalign_i    (dmisalign_i),
        .is_store_i     (is_store_i),
        .dtr_flt_vld_i  (dtr_flt_vld_i),
        .dtr_flt_code_i (dtr_flt_code_i),
        .dpa_acc_flt_i  (dpa_acc_flt_i),
        .res_o          (res)
    );

    sel_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.out = res;
    end

    generate
        if (REGISTERED) begin : g_reg
            always_ff @(posedge clk) begin
                if (!rst_n) st_q <= '0;
                else        st_q <= st_d;
            end
        end else begin : g_comb
            assign st_q = '0;
        end
    endgenerate

    assign exc_vld_o   = REGISTERED ? st_q.out.vld   : res.vld;
    assign exc_cause_o = REGISTERED ? st_q.out.cause : res.cause;

    logic any_cond;
    assign any_cond = fetch_bkpt_i | itr_flt_vld_i | ipa_acc_flt_i | illegal_i |
                      virt_instr_i | imisalign_i | ecall_i | ebreak_i | mem_bkpt_i |
                      dmisalign_i | dtr_flt_vld_i | dpa_acc_flt_i;

    assert_fetch_bkpt_wins_R1: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_bkpt_i |-> (res.vld && res.cause == C_BREAK));

    assert_itr_passthru_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!fetch_bkpt_i && itr_flt_vld_i) |-> (res.cause == itr_flt_code_i));

    assert_ecall_machine_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ecall_i && priv_i[1] && !fetch_bkpt_i && !itr_flt_vld_i && !ipa_acc_flt_i &&
         !illegal_i && !virt_instr_i && !imisalign_i) |-> (res.cause == C_ECALL_M));

    assert_idle_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !any_cond |-> (!res.vld && res.cause == '0));

    generate
        if (REGISTERED) begin : g_reg_chk
            assert_one_cycle_lag_R11: assert property (@(posedge clk) disable iff (!rst_n)
                (!any_cond && $past(rst_n)) |=> !exc_vld_o);
        end
    endgenerate
endmodule

// File: tb/sync_exc_sel_bench.sv
`timescale 1ns/1ps
module sync_exc_sel_bench;
    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst_n;
    logic fetch_bkpt, itr_vld, ipa_acc, illegal, virt_instr, imis, ecall, virt;
    logic ebreak, mem_bkpt, dmis, is_store, dtr_vld, dpa_acc;
    logic [4:0] itr_code, dtr_code;
    logic [1:0] priv;

    logic hv, lv;
    logic [4:0] hc, lc;

    int n_vec = 0;
    int n_bad = 0;

    sync_exc_sel #(.MISALIGNED_HIGH(1'b1), .REGISTERED(1'b1)) u_sync_exc_sel (
        .clk(clk), .rst_n(rst_n), .fetch_bkpt_i(fetch_bkpt), .itr_flt_vld_i(itr_vld),
        .itr_flt_code_i(itr_code), .ipa_acc_flt_i(ipa_acc), .illegal_i(illegal),
        .virt_instr_i(virt_instr), .imisalign_i(imis), .ecall_i(ecall), .priv_i(priv),
        .virt_i(virt), .ebreak_i(ebreak), .mem_bkpt_i(mem_bkpt), .dmisalign_i(dmis),
        .is_store_i(is_store), .dtr_flt_vld_i(dtr_vld), .dtr_flt_code_i(dtr_code),
        .dpa_acc_flt_i(dpa_acc), .exc_vld_o(hv), .exc_cause_o(hc));

    sync_exc_sel #(.MISALIGNED_HIGH(1'b0), .REGISTERED(1'b0)) u_sync_exc_sel_lo (
        .clk(clk), .rst_n(rst_n), .fetch_bkpt_i(fetch_bkpt), .itr_flt_vld_i(itr_vld),
        .itr_flt_code_i(itr_code), .ipa_acc_flt_i(ipa_acc), .illegal_i(illegal),
        .virt_instr_i(virt_instr), .imisalign_i(imis), .ecall_i(ecall), .priv_i(priv),
        .virt_i(virt), .ebreak_i(ebreak), .mem_bkpt_i(mem_bkpt), .dmisalign_i(dmis),
        .is_store_i(is_store), .dtr_flt_vld_i(dtr_vld), .dtr_flt_code_i(dtr_code),
        .dpa_acc_flt_i(dpa_acc), .exc_vld_o(lv), .exc_cause_o(lc));

    task automatic clear_all();
        fetch_bkpt = 0; itr_vld = 0; itr_code = 0; ipa_acc = 0; illegal = 0;
        virt_instr = 0; imis = 0; ecall = 0; priv = 2'b00; virt = 0; ebreak = 0;
        mem_bkpt = 0; dmis = 0; is_store = 0; dtr_vld = 0; dtr_code = 0; dpa_acc = 0;
    endtask

    task automatic check(string req, logic got_v, logic [4:0] got_c, logic exp_v, logic [4:0] exp_c);
        n_vec++;
        if (got_v !== exp_v || got_c !== exp_c) begin
            n_bad++;
            $display("FAIL %s: got vld=%0b cause=%0d, expected vld=%0b cause=%0d",
                     req, got_v, got_c, exp_v, exp_c);
        end
    endtask

    // Inputs change at a falling edge; registered copy is sampled one rising edge later.
    task automatic apply_check(string req, logic ehv, logic [4:0] ehc, logic elv, logic [4:0] elc);
        @(posedge clk);
        @(negedge clk);
        check({req, " reg/high"}, hv, hc, ehv, ehc);
        check({req, " comb/low"}, lv, lc, elv, elc);
    endtask

    task automatic t_reset();
        clear_all(); fetch_bkpt = 1; rst_n = 0;
        @(posedge clk); @(negedge clk);
        check("R11 reset", hv, hc, 1'b0, 5'd0);
        rst_n = 1;
    endtask

    task automatic t_r1();
        fetch_bkpt = 1; itr_vld = 1; itr_code = 12; ipa_acc = 1; illegal = 1; virt_instr = 1;
        imis = 1; ecall = 1; ebreak = 1; mem_bkpt = 1; dmis = 1; dtr_vld = 1; dtr_code = 13; dpa_acc = 1;
        apply_check("R1 all asserted", 1, 3, 1, 3);
    endtask

    task automatic t_r2_r3();
        fetch_bkpt = 0; itr_code = 20;
        apply_check("R2 guest-page fetch", 1, 20, 1, 20);
        itr_code = 1;
        apply_check("R2 access during fetch walk", 1, 1, 1, 1);
        itr_vld = 0; illegal = 1;
        apply_check("R3 fetch physical access", 1, 1, 1, 1);
    endtask

    task automatic t_r4();
        ipa_acc = 0;
        apply_check("R4 illegal", 1, 2, 1, 2);
        illegal = 0;
        apply_check("R4 virtual instr", 1, 22, 1, 22);
        virt_instr = 0;
        apply_check("R4 fetch misaligned", 1, 0, 1, 0);
        imis = 0; ecall = 0;
        apply_check("R4 ebreak", 1, 3, 1, 3);
        ebreak = 0; dmis = 0; dtr_vld = 0; dpa_acc = 0;
        apply_check("R4 data breakpoint", 1, 3, 1, 3);
        mem_bkpt = 0;
    endtask

    task automatic t_r5();
        clear_all(); ecall = 1; ebreak = 1; mem_bkpt = 1;
        priv = 2'b11; virt = 0;
        apply_check("R5 machine", 1, 11, 1, 11);
        priv = 2'b01; virt = 0;
        apply_check("R5 hs", 1, 9, 1, 9);
        priv = 2'b01; virt = 1;
        apply_check("R5 vs", 1, 10, 1, 10);
        priv = 2'b00; virt = 1;
        apply_check("R5 user virt", 1, 8, 1, 8);
        priv = 2'b00; virt = 0;
        apply_check("R5 user", 1, 8, 1, 8);
    endtask

    task automatic t_r6_r7();
        clear_all(); dmis = 1; dtr_vld = 1; dtr_code = 13; dpa_acc = 1;
        apply_check("R6 R7 load mis vs walk", 1, 4, 1, 13);
        is_store = 1; dtr_code = 23;
        apply_check("R6 R7 store mis vs walk", 1, 6, 1, 23);
        dtr_vld = 0;
        apply_check("R6 R7 store mis vs access", 1, 6, 1, 7);
        mem_bkpt = 1;
        apply_check("R6 bkpt over mis", 1, 3, 1, 3);
    endtask

    task automatic t_r8_r9();
        clear_all(); dtr_vld = 1; dtr_code = 21; dpa_acc = 1;
        apply_check("R8 guest-page data", 1, 21, 1, 21);
        dtr_code = 7;
        apply_check("R8 data walk access", 1, 7, 1, 7);
        dtr_vld = 0; is_store = 0;
        apply_check("R9 load access", 1, 5, 1, 5);
        is_store = 1;
        apply_check("R9 store access", 1, 7, 1, 7);
        dpa_acc = 0; dmis = 1; is_store = 0;
        apply_check("R9 load mis alone", 1, 4, 1, 4);
    endtask

    task automatic t_r10();
        clear_all();
        apply_check("R10 idle", 0, 0, 0, 0);
    endtask

    task automatic t_r11();
        clear_all();
        @(posedge clk); @(negedge clk);
        illegal = 1;
        #1;
        check("R11 before edge reg", hv, hc, 1'b0, 5'd0);
        check("R11 before edge comb", lv, lc, 1'b1, 5'd2);
        @(posedge clk); @(negedge clk);
        check("R11 after edge", hv, hc, 1'b1, 5'd2);
        rst_n = 0;
        @(posedge clk); @(negedge clk);
        check("R11 mid-run reset", hv, hc, 1'b0, 5'd0);
        rst_n = 1;
        clear_all();
    endtask

    initial begin
        clear_all(); rst_n = 0;
        @(negedge clk);
        t_reset();
        t_r1();
        t_r2_r3();
        t_r4();
        t_r5();
        t_r6_r7();
        t_r8_r9();
        t_r10();
        t_r11();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #40000;
        n_vec++; n_bad++;
        $display("FAIL watchdog: got hung run, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule